// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block carries a stream of data words from one clock domain into a second domain whose clock bears no fixed relation to the first. The producer side pushes words on its own clock. The consumer side pops them on its clock and sees the oldest stored word on its data output. Each side owns a binary pointer and a gray-coded copy of it. The gray copy is passed through a two-stage synchroniser into the opposite domain. Full and a half-full watermark are decoded in the write domain, and empty is decoded in the read domain.

Both enables are qualified inside the block. A push while full and a pop while empty are dropped without effect, so callers may hold an enable high without watching the flags. The flags settle in a conservative direction: full and empty clear only after the other side's pointer has crossed the synchroniser.

Each reset pin is active low and asserts asynchronously. It is released through a two-stage synchroniser in its own domain. After that release, the enable of that domain stays masked for a short guard period. A request that coincides with reset removal therefore cannot disturb a pointer.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, with no loss or duplication. While `rd_empty` is 0, `rd_data` shows the oldest stored word, and a pop on a read-clock edge advances past that word.
- R2: `rd_empty` is 1 whenever the read pointer equals the write pointer as synchronised into the read domain. In particular, `rd_empty` rises on the read-clock edge that pops the last stored word.
- R3: While `wr_full` is 1, a write request is ignored. The write pointer does not move and no stored word is overwritten.
- R4: While `rd_empty` is 1, a read request is ignored and the read pointer does not move. A word written later is still the next word delivered.
- R5: With the default depth of 16, `wr_full` rises on the write-clock edge that stores the 16th word. After a pop, `wr_full` stays 1 at the first write-clock edge after the pop and falls at the second; it never falls before that pop.
- R6: `wr_half` is 1 when the occupancy seen in the write domain is at least 8 (half the depth), and 0 below that. `wr_full` implies `wr_half`.
- R7: Each domain's internal reset is released on the second rising edge of that domain's clock after its reset pin deasserts. The domain's enable is then ignored on the next 4 rising edges, so no write happens on the first 6 write-clock edges after `wr_rst_n` rises.
- R8: While the reset pins are low, `rd_empty` is 1 and `wr_full` and `wr_half` are 0.
- R9: Each pointer crosses domains as a gray code that changes by at most one bit per step, through two flip-flop stages. `rd_empty` therefore stays 1 at the first read-clock edge after a write into an empty FIFO and falls at the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, active low, asynchronous assertion |
| wr_en | input | 1 | Write request; dropped while full or during the guard period |
| wr_data | input | DATA_W (8) | Word to store |
| wr_full | output | 1 | All entries occupied, as seen by the write domain |
| wr_half | output | 1 | Occupancy at or above half the depth, as seen by the write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, active low, asynchronous assertion |
| rd_en | input | 1 | Read request; dropped while empty or during the guard period |
| rd_data | output | DATA_W (8) | Oldest stored word (show-ahead) |
| rd_empty | output | 1 | No entry available, as seen by the read domain |

## Verification
The properties assume that both reset pins go low together at the start and that both clocks run freely afterwards. They also assume that enables and data change only between clock edges, never on an edge. The stimulus drives every input on falling edges or a fraction of a nanosecond after a rising edge. The two clock periods are chosen so that their rising edges never coincide, which keeps the edge-counting expectations of R5, R7 and R9 well defined. Random phases first favour writes and then favour reads, which drives the FIFO against both the full and the empty boundary many times.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;

  // Gray encode: adjacent binary values differ in exactly one gray bit.
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray decode: each binary bit is the XOR of all gray bits at or above it.
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
// Multi-stage flip-flop chain used both for pointer crossing and reset release.
module xfifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/xfifo_store.sv
`timescale 1ns/1ps
// Register-file storage: written on the write clock, read asynchronously.
module xfifo_store #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] rows_flat;

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic          row_en;
    logic [DW-1:0] row_q;

    assign row_en = we_i && (waddr_i == AW'(r));

    always_ff @(posedge wr_clk) begin
      if (row_en) begin
        row_q <= wdata_i;
      end
    end

    assign rows_flat[r] = row_q;
  end

  assign rdata_o = rows_flat[raddr_i];

endmodule

// File: rtl/xfifo_wr_ctl.sv
`timescale 1ns/1ps
// Write-side pointer, guard period, full and half-full decode.
module xfifo_wr_ctl
  import xfifo_pkg::*;
#(
  parameter int AW    = 4,
  parameter int GUARD = 4,
  parameter int HALF  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic [AW:0] rgray_s_i,
  output logic        we_o,
  output logic [AW-1:0] addr_o,
  output logic [AW:0] gray_o,
  output logic        full_o,
  output logic        half_o
);

  localparam int PW = AW + 1;
  localparam int GW = $clog2(GUARD + 2);

  logic [GW-1:0] guard_q, guard_d;
  logic          armed;
  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic [PW-1:0] full_pat, rbin_s, occ;

  assign armed = (guard_q == GW'(GUARD));

  always_comb begin
    guard_d  = armed ? guard_q : guard_q + 1'b1;
    // Full: the read pointer lags by exactly one wrap, so its two top gray bits differ.
    full_pat = rgray_s_i ^ {2'b11, {(PW-2){1'b0}}};
    full_o   = (gray_q == full_pat);
    rbin_s   = PW'(gray_to_bin(32'(rgray_s_i)));
    occ      = bin_q - rbin_s;
    half_o   = (occ >= PW'(HALF));
    we_o     = req_i & armed & ~full_o;
    bin_d    = bin_q + PW'(we_o);
    gray_d   = PW'(bin_to_gray(32'(bin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q <= '0;
      bin_q   <= '0;
      gray_q  <= '0;
    end else begin
      guard_q <= guard_d;
      bin_q   <= bin_d;
      gray_q  <= gray_d;
    end
  end

  assign addr_o = bin_q[AW-1:0];
  assign gray_o = gray_q;

endmodule

// File: rtl/xfifo_rd_ctl.sv
`timescale 1ns/1ps
// Read-side pointer, guard period and empty decode.
module xfifo_rd_ctl
  import xfifo_pkg::*;
#(
  parameter int AW    = 4,
  parameter int GUARD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW:0]   wgray_s_i,
  output logic [AW-1:0] addr_o,
  output logic [AW:0]   gray_o,
  output logic          empty_o
);

  localparam int PW = AW + 1;
  localparam int GW = $clog2(GUARD + 2);

  logic [GW-1:0] guard_q, guard_d;
  logic          armed;
  logic          re;
  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d;

  assign armed = (guard_q == GW'(GUARD));

  always_comb begin
    guard_d = armed ? guard_q : guard_q + 1'b1;
    empty_o = (gray_q == wgray_s_i);
    re      = req_i & armed & ~empty_o;
    bin_d   = bin_q + PW'(re);
    gray_d  = PW'(bin_to_gray(32'(bin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q <= '0;
      bin_q   <= '0;
      gray_q  <= '0;
    end else begin
      guard_q <= guard_d;
      bin_q   <= bin_d;
      gray_q  <= gray_d;
    end
  end

  assign addr_o = bin_q[AW-1:0];
  assign gray_o = gray_q;

endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO top. ADDR_W must be at least 2; SYNC_STAGES at least 2.
module xclk_fifo #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CYC   = 4
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_half,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int PW        = ADDR_W + 1;
  localparam int HALF_MARK = DEPTH / 2;

  logic              wr_rst_sync_n, rd_rst_sync_n;
  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PW-1:0]     wr_gray, rd_gray, rd_gray_in_wr, wr_gray_in_rd;

  // Reset release: asynchronous assertion, release after SYNC_STAGES edges.
  xfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .rst_n(wr_rst_n), .d_i(1'b1), .q_o(wr_rst_sync_n)
  );
  xfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .rst_n(rd_rst_n), .d_i(1'b1), .q_o(rd_rst_sync_n)
  );

  // Pointer crossings.
  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_to_wr (
    .clk(wr_clk), .rst_n(wr_rst_sync_n), .d_i(rd_gray), .q_o(rd_gray_in_wr)
  );
  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_to_rd (
    .clk(rd_clk), .rst_n(rd_rst_sync_n), .d_i(wr_gray), .q_o(wr_gray_in_rd)
  );

  xfifo_wr_ctl #(.AW(ADDR_W), .GUARD(GUARD_CYC), .HALF(HALF_MARK)) u_wr_ctl (
    .clk(wr_clk), .rst_n(wr_rst_sync_n), .req_i(wr_en), .rgray_s_i(rd_gray_in_wr),
    .we_o(wr_fire), .addr_o(wr_addr), .gray_o(wr_gray), .full_o(wr_full), .half_o(wr_half)
  );

  xfifo_rd_ctl #(.AW(ADDR_W), .GUARD(GUARD_CYC)) u_rd_ctl (
    .clk(rd_clk), .rst_n(rd_rst_sync_n), .req_i(rd_en), .wgray_s_i(wr_gray_in_rd),
    .addr_o(rd_addr), .gray_o(rd_gray), .empty_o(rd_empty)
  );

  xfifo_store #(.DW(DATA_W), .AW(ADDR_W)) u_store (
    .wr_clk(wr_clk), .we_i(wr_fire), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
module xclk_fifo_chk #(
  parameter int AW    = 4,
  parameter int GUARD = 4
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        wr_rst_n,
  input logic        rd_rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        wr_full,
  input logic        wr_half,
  input logic        rd_empty,
  input logic [AW:0] wr_gray,
  input logic [AW:0] rd_gray
);

  localparam int GW = $clog2(GUARD + 2);

  logic [GW-1:0] wr_age, rd_age;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) wr_age <= '0;
    else if (wr_age != GW'(GUARD)) wr_age <= wr_age + 1'b1;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rd_age <= '0;
    else if (rd_age != GW'(GUARD)) rd_age <= rd_age + 1'b1;
  end

  // R3
  wr_drop_when_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_full && wr_en) |=> $stable(wr_gray));

  // R4
  rd_drop_when_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_empty && rd_en) |=> $stable(rd_gray));

  // R9
  wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  // R9
  rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

  // R6
  full_implies_half_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full |-> wr_half);

  // R7
  wr_guard_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_age < GW'(GUARD)) |=> $stable(wr_gray));

  // R7
  rd_guard_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_age < GW'(GUARD)) |=> $stable(rd_gray));

endmodule

bind xclk_fifo xclk_fifo_chk #(.AW(ADDR_W), .GUARD(GUARD_CYC)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk),
  .wr_rst_n(wr_rst_sync_n), .rd_rst_n(rd_rst_sync_n),
  .wr_en(wr_en), .rd_en(rd_en),
  .wr_full(wr_full), .wr_half(wr_half), .rd_empty(rd_empty),
  .wr_gray(wr_gray), .rd_gray(rd_gray)
);

// File: tb/test_xclk_fifo.sv
`timescale 1ns/100ps
module test_xclk_fifo;

  localparam int DW    = 8;
  localparam int DEPTH = 16;

  logic          wr_clk, rd_clk;
  logic          wr_rst_n, rd_rst_n;
  logic          wr_en, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic          wr_full, wr_half, rd_empty;

  int            n_chk = 0;
  int            n_err = 0;
  bit            done  = 0;
  bit            stop_rd = 0;
  bit            wr_heavy = 1;
  logic [DW-1:0] q[$];

  xclk_fifo i_xclk_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_half(wr_half),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty)
  );

  // 250 MHz write clock; read clock at 7 ns, offset so rising edges never meet.
  initial begin
    wr_clk = 1'b0;
    forever #2 wr_clk = ~wr_clk;
  end
  initial begin
    rd_clk = 1'b0;
    #0.8;
    forever #3.5 rd_clk = ~rd_clk;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  // Write n random words on consecutive edges; returns on the falling edge after the last.
  task automatic push_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_data = DW'($urandom);
      q.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  // Pop n words on consecutive read edges, checking each against the model.
  task automatic pop_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      check(rd_empty == 1'b0, tag, rd_empty, 0);
      check(rd_data == q[0], tag, rd_data, q[0]);
      rd_en = 1'b1;
      void'(q.pop_front());
    end
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic rand_writer(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge wr_clk);
      wr_heavy = (c < cycles / 2);
      // R5: full must not be low while the model holds DEPTH words
      if (!wr_full) check(q.size() < DEPTH, "R5 full early", q.size(), DEPTH - 1);
      wr_en   = ($urandom_range(99) < (wr_heavy ? 75 : 25));
      wr_data = DW'($urandom);
      if (wr_en && !wr_full) q.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_en   = 1'b0;
    stop_rd = 1'b1;
  endtask

  task automatic rand_reader();
    while (!stop_rd) begin
      @(negedge rd_clk);
      if (!rd_empty) begin
        check(q.size() > 0, "R2 empty late", q.size(), 1);
        if (q.size() > 0) check(rd_data == q[0], "R1 random order", rd_data, q[0]);
      end
      rd_en = ($urandom_range(99) < (wr_heavy ? 30 : 70));
      if (rd_en && !rd_empty && q.size() > 0) void'(q.pop_front());
    end
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5151));
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    #1;
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    #39;
    // R8 reset state
    check(rd_empty == 1'b1, "R8 empty in reset", rd_empty, 1);
    check(wr_full == 1'b0, "R8 full in reset", wr_full, 0);
    check(wr_half == 1'b0, "R8 half in reset", wr_half, 0);

    @(negedge rd_clk);
    rd_rst_n = 1'b1;
    // R7: write held high for the 6 edges after release must be masked
    @(negedge wr_clk);
    wr_rst_n = 1'b1;
    wr_en    = 1'b1;
    wr_data  = 8'hA5;
    repeat (6) @(negedge wr_clk);
    wr_en = 1'b0;
    repeat (20) @(negedge wr_clk);
    check(wr_half == 1'b0 && wr_full == 1'b0, "R7 wr flags after guard",
          {wr_full, wr_half}, 0);
    @(negedge rd_clk);
    check(rd_empty == 1'b1, "R7 guard write dropped", rd_empty, 1);

    // R9: empty clears at the second read edge after a write
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = 8'h5A;
    q.push_back(8'h5A);
    @(posedge wr_clk);
    #0.2 wr_en = 1'b0;
    @(posedge rd_clk);
    #0.2 check(rd_empty == 1'b1, "R9 empty after 1st rd edge", rd_empty, 1);
    @(posedge rd_clk);
    #0.2 check(rd_empty == 1'b0, "R9 empty after 2nd rd edge", rd_empty, 0);
    pop_check(1, "R1 single word");
    check(rd_empty == 1'b1, "R2 empty after last pop", rd_empty, 1);

    // R6 watermark and R5 full
    repeat (6) @(negedge wr_clk);
    push_burst(7);
    check(wr_half == 1'b0, "R6 half at 7", wr_half, 0);
    check(wr_full == 1'b0, "R5 full at 7", wr_full, 0);
    push_burst(1);
    check(wr_half == 1'b1, "R6 half at 8", wr_half, 1);
    push_burst(7);
    check(wr_full == 1'b0, "R5 full at 15", wr_full, 0);
    push_burst(1);
    check(wr_full == 1'b1, "R5 full at 16", wr_full, 1);
    check(wr_half == 1'b1, "R6 half at 16", wr_half, 1);

    // R3: writes while full are dropped
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = 8'hEE;
    repeat (3) @(negedge wr_clk);
    wr_en = 1'b0;
    check(wr_full == 1'b1, "R3 full held", wr_full, 1);

    // R5: full clears on the second write edge after a pop
    repeat (4) @(negedge rd_clk);
    @(negedge rd_clk);
    check(rd_data == q[0], "R1 head while full", rd_data, q[0]);
    rd_en = 1'b1;
    @(posedge rd_clk);
    void'(q.pop_front());
    @(posedge wr_clk);
    #0.2 rd_en = 1'b0;
    check(wr_full == 1'b1, "R5 full after 1st wr edge", wr_full, 1);
    @(posedge wr_clk);
    #0.2 check(wr_full == 1'b0, "R5 full after 2nd wr edge", wr_full, 0);

    pop_check(15, "R3 no overwrite");
    check(rd_empty == 1'b1, "R3 drained", rd_empty, 1);

    // R4: reads while empty are dropped
    @(negedge rd_clk);
    rd_en = 1'b1;
    repeat (5) @(negedge rd_clk);
    rd_en = 1'b0;
    check(rd_empty == 1'b1, "R4 still empty", rd_empty, 1);
    push_burst(1);
    repeat (4) @(negedge rd_clk);
    pop_check(1, "R4 next word kept");
    check(rd_empty == 1'b1, "R2 empty again", rd_empty, 1);

    // Random traffic: write-heavy half, then read-heavy half
    fork
      rand_writer(4000);
      rand_reader();
    join

    // Drain what is left
    repeat (10) @(negedge wr_clk);
    for (int i = 0; i < 64; i++) begin
      @(negedge rd_clk);
      if (!rd_empty) begin
        check(q.size() > 0, "R2 drain", q.size(), 1);
        if (q.size() > 0) begin
          check(rd_data == q[0], "R1 drain order", rd_data, q[0]);
          void'(q.pop_front());
        end
        rd_en = 1'b1;
      end else begin
        rd_en = 1'b0;
      end
    end
    rd_en = 1'b0;
    check(q.size() == 0, "R1 nothing lost", q.size(), 0);
    check(rd_empty == 1'b1, "R2 final empty", rd_empty, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule